// File: doc/BRIEF.md
# Divided-Clock Time Tag Counter

This block produces the sampling rate for an acquisition channel and keeps a free-running time tag. A static strap chooses the rate source: either every cycle of the system clock, or each rising edge of a slower external clock that is sampled into the system clock domain. Two independent divide-by-two stages can then thin the source ticks to a half or a quarter rate. The result is a one-cycle enable pulse, `samp_en`. No clocks are derived from the system clock, so every register in the block runs on the single system clock.

A counter of `TAG_W` bits, 30 by default, advances on every enable pulse and wraps to zero. An external clear passes through a two-flop synchronizer. The counter holds at zero at every enable for as long as the synchronized clear stays high, and it resumes counting after the clear is released.

A stop input is sampled at each enable. A rising stop starts a capture that completes three enables later, so the captured tag is three counts ahead of the count at the moment the stop was seen. The arrival time of the stop is therefore (tag − 3) divided periods after the clear was released. The tag is presented with a one-cycle valid pulse, ready for an event header.

Top module: `tt_timebase`

## Requirements
- R1: After reset, `count`, `tag` and `tag_vld` are all 0.
- R2: With `src_sel`=0, the source ticks on every clock cycle. With `src_sel`=1, the source ticks once for each rising edge of `ext_clk`, in the cycle after that rising edge has been sampled at two clock edges.
- R3: `div_en[0]` and `div_en[1]` each halve the rate. `samp_en` is high on every N-th source tick, where N is 1, 2 or 4 according to the number of bits set, and the first pulse comes on the N-th tick after reset.
- R4: At each `samp_en` pulse without a synchronized clear, `count` increases by exactly 1. Without `samp_en`, `count` is unchanged.
- R5: The count wraps from 2^TAG_W − 1 to 0.
- R6: `clr_in` passes through two flops. At every `samp_en` where the synchronized clear is high, `count` becomes 0. Counting resumes at the first `samp_en` after the synchronized clear has fallen.
- R7: `stop_in` is sampled at each `samp_en`. A sample that is high after a low sample starts a capture. At the third later `samp_en`, `tag` takes the `count` value held just before that enable, and `tag_vld` is high for exactly the following cycle. Without a clear in between, the captured tag equals the stop-time count plus 3.
- R8: If `stop_in` is held high over many enables, only one capture results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Static source select: 0 = system clock, 1 = external clock edges |
| ext_clk | input | 1 | External rate clock, sampled as a level |
| div_en | input | 2 | Static divide-by-two enables, one per stage |
| clr_in | input | 1 | Asynchronous clear request for the counter |
| stop_in | input | 1 | Stop request, sampled at the divided rate |
| samp_en | output | 1 | Divided sampling enable pulse |
| count | output | TAG_W | Live time tag count |
| tag | output | TAG_W | Tag captured for the last stop |
| tag_vld | output | 1 | One-cycle pulse when `tag` updates |

## Verification
The assertions check the following on every cycle: the counter steps by one, or holds, or goes to zero as the enable and the synchronized clear dictate; divided enables are never back to back; the undivided internal source is always enabled; and each capture pulse follows an enable and is never repeated. Only the bench scenarios can show the exact divide phases and the sampling latency of the external clock. The same applies to the three-enable capture offset, the wrap at full width (shown on a narrow second instance) and the single capture for a held stop. The bench compares all of these against a behavioural model on every clock.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int unsigned TT_STAGES = 2;   // divide-by-two stages
    localparam int unsigned TT_LAG    = 3;   // enables from stop edge to capture
    localparam int unsigned TT_SYNC   = 2;   // synchronizer depth

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;
endpackage

// File: rtl/tt_tick_src.sv
module tt_tick_src
    import tt_pkg::*;
#(
    parameter int unsigned SYNC_N = TT_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic ext_clk,
    output logic tick
);
    typedef struct packed {
        logic [SYNC_N:0] hist;
    } src_t;

    src_t src_d, src_q;
    logic ext_edge;

    always_comb begin
        src_d      = src_q;
        src_d.hist = {src_q.hist[SYNC_N-1:0], ext_clk};
        ext_edge   = src_q.hist[SYNC_N-1] & ~src_q.hist[SYNC_N];
        tick       = (src_e'(src_sel) == SRC_EXT) ? ext_edge : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    // R2: an external edge yields a single tick
    a_r2_ext_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && tick) |=> !tick);
endmodule

// File: rtl/tt_div_chain.sv
module tt_div_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] div_en,
    input  logic              tick_in,
    output logic              tick_out
);
    typedef struct packed {
        logic [STAGES-1:0] tgl;
    } div_t;

    div_t div_d, div_q;
    logic [STAGES:0] chain;

    assign chain[0] = tick_in;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign chain[g+1] = div_en[g] ? (chain[g] & div_q.tgl[g]) : chain[g];
    end

    always_comb begin
        div_d = div_q;
        for (int i = 0; i < STAGES; i++) begin
            if (div_en[i] && chain[i]) div_d.tgl[i] = ~div_q.tgl[i];
        end
    end

    assign tick_out = chain[STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R3: any active divider forbids back-to-back enables
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        ((|div_en) && tick_out) |=> !tick_out);
endmodule

// File: rtl/tt_clr_sync.sv
module tt_clr_sync #(
    parameter int unsigned N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_in,
    output logic clr_s
);
    typedef struct packed {
        logic [N-1:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[N-2:0], clr_in};
    end

    assign clr_s = sync_q.sh[N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/tt_tag_core.sv
module tt_tag_core #(
    parameter int unsigned W   = 30,
    parameter int unsigned LAG = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr_s,
    input  logic         stop_in,
    output logic [W-1:0] count,
    output logic [W-1:0] tag,
    output logic         tag_vld
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0]   cnt;
        logic [W-1:0]   tag;
        logic [LAG-1:0] sh;
        logic           stp_prev;
        logic           vld;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.vld = 1'b0;
        if (en) begin
            core_d.cnt      = clr_s ? '0 : core_q.cnt + ONE;
            core_d.stp_prev = stop_in;
            core_d.sh       = {core_q.sh[LAG-2:0], stop_in & ~core_q.stp_prev};
            if (core_q.sh[LAG-1]) begin
                core_d.tag = core_q.cnt;
                core_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign count   = core_q.cnt;
    assign tag     = core_q.tag;
    assign tag_vld = core_q.vld;

    // R4: step by one on an enable without clear
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr_s) |=> count == $past(count) + ONE);
    // R4: no enable, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    // R6: synchronized clear forces zero
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr_s) |=> count == '0);
    // R7: a capture only follows an enable
    a_r7_vld_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        tag_vld |-> $past(en));
    // R8: capture pulses never repeat in consecutive cycles
    a_r8_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        tag_vld |=> !tag_vld);
endmodule

// File: rtl/tt_timebase.sv
module tt_timebase
    import tt_pkg::*;
#(
    parameter int unsigned TAG_W = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_sel,
    input  logic                 ext_clk,
    input  logic [TT_STAGES-1:0] div_en,
    input  logic                 clr_in,
    input  logic                 stop_in,
    output logic                 samp_en,
    output logic [TAG_W-1:0]     count,
    output logic [TAG_W-1:0]     tag,
    output logic                 tag_vld
);
    logic base_tick;
    logic clr_s;

    tt_tick_src #(.SYNC_N(TT_SYNC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .ext_clk (ext_clk),
        .tick    (base_tick)
    );

    tt_div_chain #(.STAGES(TT_STAGES)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_en   (div_en),
        .tick_in  (base_tick),
        .tick_out (samp_en)
    );

    tt_clr_sync #(.N(TT_SYNC)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_in (clr_in),
        .clr_s  (clr_s)
    );

    tt_tag_core #(.W(TAG_W), .LAG(TT_LAG)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (samp_en),
        .clr_s   (clr_s),
        .stop_in (stop_in),
        .count   (count),
        .tag     (tag),
        .tag_vld (tag_vld)
    );

    // R2 R3: internal source with no division enables every cycle
    a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && div_en == '0) |-> samp_en);
endmodule

// File: tb/tb_tt_timebase.sv
`timescale 1ns/1ps
module tb_tt_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] div_en = 2'b00;
    logic       clr_in = 1'b0;
    logic       stop_in = 1'b0;

    logic        samp_en, tag_vld, samp_en_w, tag_vld_w;
    logic [29:0] count, tag;
    logic [5:0]  count_w, tag_w;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    tt_timebase dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_clk(ext_clk),
        .div_en(div_en), .clr_in(clr_in), .stop_in(stop_in),
        .samp_en(samp_en), .count(count), .tag(tag), .tag_vld(tag_vld)
    );

    tt_timebase #(.TAG_W(6)) dut_w (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_clk(ext_clk),
        .div_en(div_en), .clr_in(clr_in), .stop_in(stop_in),
        .samp_en(samp_en_w), .count(count_w), .tag(tag_w), .tag_vld(tag_vld_w)
    );

    // behavioural reference state
    bit [2:0]    m_ext = '0;
    int          m_ticks = 0;
    bit          m_c1 = 0, m_c2 = 0;
    longint      m_cnt = 0, m_cntw = 0, m_tag = 0, m_tagw = 0;
    bit [2:0]    m_pend = '0;
    bit          m_prev = 0, m_vld = 0;
    localparam longint MASK30 = (64'd1 << 30) - 1;
    localparam longint MASK6  = 63;

    function automatic bit exp_en();
        bit t;
        int n;
        t = src_sel ? (m_ext[1] && !m_ext[2]) : 1'b1;
        n = 1 << (int'(div_en[0]) + int'(div_en[1]));
        return t && (((m_ticks + 1) % n) == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ext = '0; m_ticks = 0; m_c1 = 0; m_c2 = 0;
            m_cnt = 0; m_cntw = 0; m_tag = 0; m_tagw = 0;
            m_pend = '0; m_prev = 0; m_vld = 0;
        end else begin
            bit e, t, hit;
            e = exp_en();
            t = src_sel ? (m_ext[1] && !m_ext[2]) : 1'b1;
            if (t) m_ticks++;
            m_vld = 0;
            if (e) begin
                hit = m_pend[2];
                if (hit) begin
                    m_tag = m_cnt; m_tagw = m_cntw; m_vld = 1;
                end
                m_pend = {m_pend[1:0], stop_in && !m_prev};
                m_prev = stop_in;
                m_cnt  = m_c2 ? 0 : ((m_cnt + 1) & MASK30);
                m_cntw = m_c2 ? 0 : ((m_cntw + 1) & MASK6);
            end
            m_c2 = m_c1; m_c1 = clr_in;
            m_ext = {m_ext[1:0], ext_clk};
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    int  sen_seen = 0;
    int  vld_seen = 0;
    bit  seen_wrap = 0;
    longint prev_w = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(samp_en == exp_en(), "R3 samp_en", samp_en, exp_en());
            chk(count == m_cnt, "R4 count", count, m_cnt);
            chk(tag == m_tag, "R7 tag", tag, m_tag);
            chk(tag_vld == m_vld, "R7 tag_vld", tag_vld, m_vld);
            chk(count_w == m_cntw, "R5 narrow count", count_w, m_cntw);
            chk(tag_w == m_tagw, "R7 narrow tag", tag_w, m_tagw);
            if (samp_en) sen_seen++;
            if (tag_vld) vld_seen++;
            if (prev_w == 63 && count_w == 0 && !clr_in) seen_wrap = 1;
            prev_w = count_w;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic start(input bit s, input bit d0, input bit d1);
        rst_n = 0; src_sel = s; div_en = {d1, d0};
        ext_clk = 0; clr_in = 0; stop_in = 0;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        chk(count == 0, "R1 count after reset", count, 0);
        chk(tag == 0, "R1 tag after reset", tag, 0);
        chk(tag_vld == 0, "R1 tag_vld after reset", tag_vld, 0);
        cyc(1);
    endtask

    task automatic ext_run(input int halves, input int hold);
        int rises = 0;
        sen_seen = 0;
        for (int i = 0; i < halves; i++) begin
            ext_clk = ~ext_clk;
            if (ext_clk) rises++;
            if (i == 8)  stop_in = 1;
            if (i == 8 + hold) stop_in = 0;
            if (i == 20) clr_in = 1;
            if (i == 20 + hold) clr_in = 0;
            if (i == 26) stop_in = 1;
            if (i == 26 + hold) stop_in = 0;
            cyc(3);
        end
        cyc(4);
        if (div_en == 2'b00)
            chk(sen_seen == rises, "R2 one enable per ext rise", sen_seen, rises);
    endtask

    initial begin
        // internal, undivided
        start(0, 0, 0);
        cyc(10);
        stop_in = 1; cyc(1); stop_in = 0;
        cyc(10);
        clr_in = 1; cyc(4); clr_in = 0;
        cyc(80);
        vld_seen = 0;
        stop_in = 1; cyc(20); stop_in = 0; cyc(8);
        chk(vld_seen == 1, "R8 held stop captures once", vld_seen, 1);
        chk(seen_wrap, "R5 narrow counter wrapped", seen_wrap, 1);

        // internal, divide by 4
        start(0, 1, 1);
        cyc(5);
        stop_in = 1; cyc(4); stop_in = 0;
        cyc(30);
        clr_in = 1; cyc(8);
        @(negedge clk);
        chk(count == 0, "R6 held at zero during clear", count, 0);
        cyc(1);
        cyc(8);
        clr_in = 0;
        cyc(40);
        chk(count != 0, "R6 counting resumed", count, m_cnt);

        // internal, divide by 2 via the second stage
        start(0, 0, 1);
        cyc(7);
        stop_in = 1; cyc(2); stop_in = 0;
        cyc(30);

        // external, undivided and divided
        start(1, 0, 0);
        ext_run(60, 4);
        start(1, 1, 0);
        ext_run(60, 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule